// File: doc/BRIEF.md
# Reference Phase Accumulator with Restart

This block produces the reference phase of an all-digital phase-locked loop and turns it into a phase error. On every reference clock edge it adds a frequency control word to a phase register. The word has an integer part and a fractional part. It then subtracts the oscillator phase from the new reference phase. The oscillator phase is the oscillator edge count (integer part) joined to the fractional reading of the time-to-digital converter. The result is a signed two's-complement error, and the loop filter downstream consumes it.

The loop runs in two phases. During coarse tuning the error output is held at zero. When fine tuning is requested, the block performs a restart on the first reference edge of the request. The integer part of the reference phase is loaded with the oscillator edge count, so the integer error becomes zero. The fractional part is handled in one of two ways, chosen by a control input:
- It is copied from the converter reading, so the whole error is cleared.
- It is loaded from a programmable preset, so the locked phase can be placed on a steep part of the converter staircase rather than on a flat step.

In an integer-N setup the fractional control word is zero, so the fractional reference phase keeps whatever value the restart gave it.

Top module: `ref_phase_restart`

## Requirements
- R1: On every clock edge that is not a restart edge, the reference phase becomes its previous value plus the control word `{fcw_int_i, fcw_frac_i}`.
- R2: The reference phase and the phase error are computed modulo 2^(INT_W+FRAC_W). The integer field wraps from 0xFF to 0x00 with the default 8 integer bits.
- R3: On a clock edge that is not a restart edge and where `fine_req_i` is high, `phase_err_o` is loaded with (new reference phase) − `{osc_count_i, tdc_frac_i}` as a two's-complement value. It is visible after that edge.
- R4: A restart edge is a clock edge where `fine_req_i` is high and `fine_o` was low (coarse mode). `restart_o` is high for exactly the one cycle after that edge. Holding `fine_req_i` high never causes a second restart.
- R5: On a restart edge, the integer field (upper INT_W bits) of the reference phase is loaded with `osc_count_i`, and `phase_err_o` becomes zero.
- R6: On a restart edge with `frac_hold_i` low, the fractional field (lower FRAC_W bits) of the reference phase is loaded with `tdc_frac_i`.
- R7: On a restart edge with `frac_hold_i` high, the fractional field is loaded with `frac_preset_i`, and `tdc_frac_i` is ignored.
- R8: After an edge where `fine_req_i` is low, `fine_o` is low and `phase_err_o` is zero, while the accumulator keeps running.
- R9: While `rst` is high at a clock edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| fcw_int_i | input | INT_W | Integer part of the frequency control word |
| fcw_frac_i | input | FRAC_W | Fractional part of the frequency control word |
| osc_count_i | input | INT_W | Oscillator edge count sampled at this reference edge |
| tdc_frac_i | input | FRAC_W | Fractional converter reading for this reference edge |
| fine_req_i | input | 1 | High requests fine tuning, low means coarse tuning |
| frac_hold_i | input | 1 | High: restart loads the preset fraction instead of the converter reading |
| frac_preset_i | input | FRAC_W | Fraction loaded at restart when `frac_hold_i` is high |
| ref_phase_o | output | INT_W+FRAC_W | Reference phase, integer field on top |
| phase_err_o | output | INT_W+FRAC_W | Signed phase error (two's complement) |
| fine_o | output | 1 | Fine mode active |
| restart_o | output | 1 | One-cycle flag marking a restart edge |

## Verification
All outputs are registered, so every result appears one clock after the edge that sampled its inputs; nothing is delayed by two clocks. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. The expected reference phase is held in a bench variable and advanced by the same one edge. The restart cases check three things: that the reload wins over accumulation on the very edge where the request first appears, that the next edge with the request still held only accumulates, and that the error comes out negative and across the integer wrap one edge after a restart.

// File: rtl/ref_phase_pkg.sv
package ref_phase_pkg;

    localparam int INT_W_DEF  = 8;
    localparam int FRAC_W_DEF = 16;

    typedef enum logic {
        MODE_COARSE = 1'b0,
        MODE_FINE   = 1'b1
    } loop_mode_e;

    typedef struct packed {
        logic       restart;
        loop_mode_e mode;
    } mode_ctl_t;

    function automatic mode_ctl_t next_mode(input logic req, input loop_mode_e cur);
        mode_ctl_t c;
        c.mode    = req ? MODE_FINE : MODE_COARSE;
        c.restart = req && (cur == MODE_COARSE);
        return c;
    endfunction

endpackage

// File: rtl/mode_ctrl.sv
module mode_ctrl
    import ref_phase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fine_req_i,
    output mode_ctl_t  ctl_next_o,
    output loop_mode_e mode_q_o,
    output logic       restart_q_o
);

    loop_mode_e mode_q;
    logic       restart_q;

    assign ctl_next_o = next_mode(fine_req_i, mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_COARSE;
            restart_q <= 1'b0;
        end else begin
            mode_q    <= ctl_next_o.mode;
            restart_q <= ctl_next_o.restart;
        end
    end

    assign mode_q_o    = mode_q;
    assign restart_q_o = restart_q;

    AST_RESTART_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        restart_q |=> !restart_q); // R4

endmodule

// File: rtl/ref_accum.sv
module ref_accum #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 16,
    localparam int W     = INT_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] fcw_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] ref_next_o,
    output logic [W-1:0] ref_q_o
);

    logic [W-1:0] ref_q;

    always_comb begin
        if (load_i) ref_next_o = load_val_i;
        else        ref_next_o = ref_q + fcw_i;
    end

    always_ff @(posedge clk) begin
        if (rst) ref_q <= '0;
        else     ref_q <= ref_next_o;
    end

    assign ref_q_o = ref_q;

    AST_ACCUM_STEP: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ref_q == $past(ref_q + fcw_i)); // R1

endmodule

// File: rtl/phase_err_calc.sv
module phase_err_calc #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 16,
    localparam int W     = INT_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         zero_i,
    input  logic [W-1:0] ref_next_i,
    input  logic [W-1:0] osc_phase_i,
    output logic [W-1:0] err_o
);

    logic [W-1:0] diff;
    logic [W-1:0] err_q;

    assign diff = ref_next_i - osc_phase_i;

    always_ff @(posedge clk) begin
        if (rst)         err_q <= '0;
        else if (zero_i) err_q <= '0;
        else             err_q <= diff;
    end

    assign err_o = err_q;

endmodule

// File: rtl/ref_phase_restart.sv
module ref_phase_restart
    import ref_phase_pkg::*;
#(
    parameter int INT_W  = INT_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF,
    localparam int W     = INT_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [INT_W-1:0]  fcw_int_i,
    input  logic [FRAC_W-1:0] fcw_frac_i,
    input  logic [INT_W-1:0]  osc_count_i,
    input  logic [FRAC_W-1:0] tdc_frac_i,
    input  logic              fine_req_i,
    input  logic              frac_hold_i,
    input  logic [FRAC_W-1:0] frac_preset_i,
    output logic [W-1:0]      ref_phase_o,
    output logic [W-1:0]      phase_err_o,
    output logic              fine_o,
    output logic              restart_o
);

    mode_ctl_t         ctl_next;
    loop_mode_e        mode_q;
    logic [W-1:0]      ref_next;
    logic [W-1:0]      osc_phase;
    logic [W-1:0]      restart_val;
    logic [FRAC_W-1:0] restart_frac;
    logic              err_zero;

    assign osc_phase    = {osc_count_i, tdc_frac_i};
    assign restart_frac = frac_hold_i ? frac_preset_i : tdc_frac_i;
    assign restart_val  = {osc_count_i, restart_frac};
    assign err_zero     = ctl_next.restart || (ctl_next.mode == MODE_COARSE);

    mode_ctrl u_mode (
        .clk         (clk),
        .rst         (rst),
        .fine_req_i  (fine_req_i),
        .ctl_next_o  (ctl_next),
        .mode_q_o    (mode_q),
        .restart_q_o (restart_o)
    );

    ref_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_accum (
        .clk        (clk),
        .rst        (rst),
        .load_i     (ctl_next.restart),
        .fcw_i      ({fcw_int_i, fcw_frac_i}),
        .load_val_i (restart_val),
        .ref_next_o (ref_next),
        .ref_q_o    (ref_phase_o)
    );

    phase_err_calc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_err (
        .clk         (clk),
        .rst         (rst),
        .zero_i      (err_zero),
        .ref_next_i  (ref_next),
        .osc_phase_i (osc_phase),
        .err_o       (phase_err_o)
    );

    assign fine_o = (mode_q == MODE_FINE);

    AST_RESTART_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
        restart_o |-> phase_err_o == '0); // R5

    AST_RESTART_INT_LOAD: assert property (@(posedge clk) disable iff (rst)
        restart_o |-> ref_phase_o[W-1:FRAC_W] == $past(osc_count_i)); // R5

    AST_RESTART_FRAC_LOAD: assert property (@(posedge clk) disable iff (rst)
        restart_o |-> ref_phase_o[FRAC_W-1:0] ==
            $past(frac_hold_i ? frac_preset_i : tdc_frac_i)); // R6

    AST_COARSE_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
        !fine_o |-> phase_err_o == '0); // R8

    AST_RESTART_ENTERS_FINE: assert property (@(posedge clk) disable iff (rst)
        restart_o |-> fine_o && !$past(fine_o)); // R4

endmodule

// File: tb/ref_phase_restart_tb_top.sv
`timescale 1ns/1ps
module ref_phase_restart_tb_top;

    localparam int INT_W  = 8;
    localparam int FRAC_W = 16;
    localparam int W      = INT_W + FRAC_W;

    logic              clk = 1'b0;
    logic              rst;
    logic [INT_W-1:0]  fcw_int;
    logic [FRAC_W-1:0] fcw_frac;
    logic [INT_W-1:0]  osc_count;
    logic [FRAC_W-1:0] tdc_frac;
    logic              fine_req;
    logic              frac_hold;
    logic [FRAC_W-1:0] frac_preset;
    logic [W-1:0]      ref_phase;
    logic [W-1:0]      phase_err;
    logic              fine;
    logic              restart;

    int n_run  = 0;
    int n_fail = 0;
    logic [W-1:0] ref_m;

    always #4 clk = ~clk;

    ref_phase_restart #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .fcw_int_i     (fcw_int),
        .fcw_frac_i    (fcw_frac),
        .osc_count_i   (osc_count),
        .tdc_frac_i    (tdc_frac),
        .fine_req_i    (fine_req),
        .frac_hold_i   (frac_hold),
        .frac_preset_i (frac_preset),
        .ref_phase_o   (ref_phase),
        .phase_err_o   (phase_err),
        .fine_o        (fine),
        .restart_o     (restart)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic test_reset();
        rst = 1'b1; fcw_int = 8'h01; fcw_frac = 16'h8000;
        osc_count = '0; tdc_frac = '0; fine_req = 1'b0;
        frac_hold = 1'b0; frac_preset = '0;
        tick(); tick();
        check("R9 ref", ref_phase, '0);
        check("R9 err", phase_err, '0);
        check("R9 fine", {23'b0, fine}, '0);
        check("R9 restart", {23'b0, restart}, '0);
        rst = 1'b0;
        ref_m = '0;
    endtask

    task automatic test_coarse();
        for (int i = 0; i < 3; i++) begin
            osc_count = 8'h55; tdc_frac = 16'h1111;
            tick();
            ref_m = ref_m + 24'h018000;
            check("R1 coarse accumulate", ref_phase, ref_m);
            check("R8 coarse err zero", phase_err, '0);
        end
        check("R8 fine low", {23'b0, fine}, '0);
    endtask

    task automatic test_restart_match();
        fcw_int = 8'h05; fcw_frac = 16'h0000;
        osc_count = 8'h37; tdc_frac = 16'h1234; fine_req = 1'b1; frac_hold = 1'b0;
        frac_preset = 16'hAAAA;
        tick();
        ref_m = 24'h371234;
        check("R5 R6 restart load", ref_phase, ref_m);
        check("R5 restart err zero", phase_err, '0);
        check("R4 restart flag", {23'b0, restart}, 24'd1);
        osc_count = 8'h3C; tdc_frac = 16'h1200;
        tick();
        ref_m = ref_m + 24'h050000;
        check("R1 accumulate after restart", ref_phase, ref_m);
        check("R3 positive err", phase_err, 24'h000034);
        check("R4 restart one cycle", {23'b0, restart}, '0);
        osc_count = 8'h40; tdc_frac = 16'h1234;
        tick();
        ref_m = ref_m + 24'h050000;
        check("R4 held request no reload", ref_phase, ref_m);
        check("R3 integer err", phase_err, 24'h010000);
    endtask

    task automatic test_restart_preset();
        fine_req = 1'b0;
        tick();
        ref_m = ref_m + 24'h050000;
        check("R8 back to coarse err", phase_err, '0);
        check("R8 coarse accumulates", ref_phase, ref_m);
        fine_req = 1'b1; frac_hold = 1'b1; frac_preset = 16'h8000;
        osc_count = 8'h10; tdc_frac = 16'h9000;
        tick();
        ref_m = 24'h108000;
        check("R7 preset fraction load", ref_phase, ref_m);
        check("R4 second restart", {23'b0, restart}, 24'd1);
        osc_count = 8'h15; tdc_frac = 16'h9000;
        tick();
        ref_m = ref_m + 24'h050000;
        check("R3 negative err", phase_err, 24'hFFF000);
    endtask

    task automatic test_wrap();
        fine_req = 1'b0; frac_hold = 1'b0;
        tick();
        fcw_int = 8'h04;
        fine_req = 1'b1; osc_count = 8'hFE; tdc_frac = 16'h0000;
        tick();
        ref_m = 24'hFE0000;
        check("R6 restart at FE", ref_phase, ref_m);
        tick();
        check("R2 integer wrap", ref_phase, 24'h020000);
        check("R2 err across wrap", phase_err, 24'h040000);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_coarse();
        test_restart_match();
        test_restart_preset();
        test_wrap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule